// File: doc/BRIEF.md
# Answer-Side Handshake Phase Sequencer

This block schedules the answer-side connection handshake of a low-speed modem of the 1200/2400 bit/s class. A single 600 Hz tick enable (one tick = 5/3 ms) drives every timer. The block walks the transmit datapath through a fixed series of phases: answer tone, a silent gap, unscrambled binary ones, a further gap during which unscrambled ones continue, scrambled ones, and a data delay during which scrambled ones continue. It then selects data. It raises a data-ready flag once the data phase is reached and the receive side has been qualified.

Each phase length comes from an 8-bit configuration register written through a simple write port. Different phases count in different units: 1 s, 53.3 ms (32 ticks) or single ticks. A one-cycle fast-connect strobe loads a short profile that leaves only a 400 ms answer tone. A separate qualifier watches a receive-side "scrambled ones detected" input. It declares the receiver qualified once the input has stayed high for a programmable number of ticks. Tone synthesis, modulation, scrambling and carrier detection are outside the block.

Top module: `ansHandshakeSeq`

## Requirements
- R1: After reset the block is idle: txAnsTone, txUnscrOnes, txScrOnes, txData, rxOnesQual (while rxOnesIn is low) and dataReady are all low.
- R2: Configuration registers are written by wrEn with wrAddr/wrData. Each register is listed as address, name, reset value, unit:
  - 0, tone seconds, 0x03, 600 ticks.
  - 1, fine tone, 0x5A, 1 tick.
  - 2, tone gap, 0x2D, 1 tick.
  - 3, unscrambled-ones length, 0x5D, 1 tick.
  - 4, scrambled-ones gap, 0x09, 32 ticks.
  - 5, scrambled-ones length, 0xA2, 1 tick.
  - 6, data delay low byte, 0xCB, 1 tick.
  - 7, data delay high byte, 0x08, 256 ticks of data delay.
  - 8, receive qualify length, 0xA2, 1 tick.
- R3: A start pulse while idle or in the data phase begins the sequence. The phases run in the order tone, tone gap, unscrambled ones, scrambled-ones gap, scrambled ones, data delay, data. The output code is: tone gives txAnsTone; tone gap gives no output; unscrambled ones and its gap give txUnscrOnes; scrambled ones and data delay give txScrOnes; data gives txData.
- R4: When the tone-seconds register is nonzero, the tone lasts that value times 600 ticks, and the fine tone register is ignored.
- R5: When the tone-seconds register is zero, the tone lasts the fine tone register value in ticks.
- R6: The tone gap, unscrambled-ones and scrambled-ones lengths last their value in ticks. The scrambled-ones gap lasts its value times 32 ticks.
- R7: The data delay lasts high*256 + low ticks.
- R8: A phase whose length is zero is skipped in the same cycle, so the next nonzero phase (or data) starts at once.
- R9: A fastLoad pulse sets the fine tone register to 0xF0 and every other register to zero. It takes priority over a write in the same cycle.
- R10: abort returns the block to idle from any phase on the next edge, with priority over start.
- R11: rxOnesQual is high when rxOnesIn has been high across at least the receive qualify length of tick edges. It falls as soon as rxOnesIn falls, and a new qualification restarts from zero.
- R12: dataReady is high exactly when the data phase is selected and rxOnesQual is high.
- R13: Phase timers advance only on edges with tickEn high. A start pulse during an active phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 600 Hz tick enable, one clock wide |
| start | input | 1 | Begin the handshake sequence |
| abort | input | 1 | Return to idle |
| fastLoad | input | 1 | Load the fast-connect length profile |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| rxOnesIn | input | 1 | Receive side currently detects scrambled ones |
| txAnsTone | output | 1 | Transmit answer tone |
| txUnscrOnes | output | 1 | Transmit unscrambled ones |
| txScrOnes | output | 1 | Transmit scrambled ones |
| txData | output | 1 | Transmit user data |
| rxOnesQual | output | 1 | Receive scrambled ones qualified |
| dataReady | output | 1 | Data phase reached and receiver qualified |

## Verification
The phase outputs are decoded from one state register. They change on the clock edge that samples start, and on the edge of the final tick of each phase. A phase of L ticks is therefore visible for L cycles when tickEn is high every cycle. The bench drives inputs and samples at the falling edge. It counts run lengths of the output code, so each measured length must equal the programmed tick count exactly. rxOnesQual rises after the programmed number of tick edges and drops combinationally with rxOnesIn. The bench therefore samples it one falling edge per tick, and shortly after changing the input.

// File: rtl/hsPkg.sv
package hsPkg;
  localparam int REG_W  = 8;
  localparam int NREG   = 9;
  localparam int ADDR_W = 4;

  localparam int REG_TONE_SEC  = 0;
  localparam int REG_TONE_FINE = 1;
  localparam int REG_TONE_GAP  = 2;
  localparam int REG_PLAIN     = 3;
  localparam int REG_SCR_GAP   = 4;
  localparam int REG_SCR       = 5;
  localparam int REG_DLY_LO    = 6;
  localparam int REG_DLY_HI    = 7;
  localparam int REG_RX_LEN    = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_TONE  = 3'd1,
    PH_TGAP  = 3'd2,
    PH_PLAIN = 3'd3,
    PH_SGAP  = 3'd4,
    PH_SCR   = 3'd5,
    PH_DDLY  = 3'd6,
    PH_DONE  = 3'd7
  } phase_t;

  typedef struct packed {
    logic   load;
    phase_t loadSel;
    logic   dec;
  } cntStrobe_t;

  function automatic logic [REG_W-1:0] rstVal(input int idx);
    case (idx)
      REG_TONE_SEC:  return 8'h03;
      REG_TONE_FINE: return 8'h5A;
      REG_TONE_GAP:  return 8'h2D;
      REG_PLAIN:     return 8'h5D;
      REG_SCR_GAP:   return 8'h09;
      REG_SCR:       return 8'hA2;
      REG_DLY_LO:    return 8'hCB;
      REG_DLY_HI:    return 8'h08;
      default:       return 8'hA2;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] fastVal(input int idx);
    return (idx == REG_TONE_FINE) ? 8'hF0 : 8'h00;
  endfunction
endpackage

// File: rtl/hsRegs.sv
module hsRegs
  import hsPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [REG_W-1:0]             wrData,
  input  logic                         fastLoad,
  output logic [NREG-1:0][REG_W-1:0]   cfgQ
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                                cfgQ[i] <= rstVal(i);
      else if (fastLoad)                        cfgQ[i] <= fastVal(i);
      else if (wrEn && wrAddr == ADDR_W'(i))    cfgQ[i] <= wrData;
    end
  end

  // R9: the fast profile wins over a same-cycle write
  a_r9_fast_profile: assert property (@(posedge clk) disable iff (!rstN)
    fastLoad |=> (cfgQ[REG_TONE_FINE] == 8'hF0) && (cfgQ[REG_TONE_SEC] == '0)
                 && (cfgQ[REG_DLY_HI] == '0) && (cfgQ[REG_RX_LEN] == '0));
endmodule

// File: rtl/hsDatapath.sv
module hsDatapath
  import hsPkg::*;
#(
  parameter int TICKS_PER_SEC  = 600,
  parameter int TICKS_PER_SLOW = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tickEn,
  input  cntStrobe_t                  strb,
  input  logic [NREG-1:0][REG_W-1:0]  cfgQ,
  input  logic                        rxOnesIn,
  output logic [6:1]                  zeroMask,
  output logic                        cntLast,
  output logic                        cntZero,
  output logic                        rxQual
);
  localparam int MAX_REG  = (1 << REG_W) - 1;
  localparam int MAX_SEC  = MAX_REG * TICKS_PER_SEC;
  localparam int MAX_SLOW = MAX_REG * TICKS_PER_SLOW;
  localparam int MAX_DLY  = (1 << (2 * REG_W)) - 1;
  localparam int MAX_A    = (MAX_SEC > MAX_SLOW) ? MAX_SEC : MAX_SLOW;
  localparam int MAX_T    = (MAX_A > MAX_DLY) ? MAX_A : MAX_DLY;
  localparam int CNT_W    = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] lenArr [0:7];
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] rxCnt;
  logic [REG_W-1:0] rxLen;

  // phase lengths converted to base ticks
  always_comb begin
    lenArr[PH_IDLE]  = '0;
    lenArr[PH_TONE]  = (cfgQ[REG_TONE_SEC] != '0)
                       ? CNT_W'(cfgQ[REG_TONE_SEC]) * CNT_W'(TICKS_PER_SEC)
                       : CNT_W'(cfgQ[REG_TONE_FINE]);
    lenArr[PH_TGAP]  = CNT_W'(cfgQ[REG_TONE_GAP]);
    lenArr[PH_PLAIN] = CNT_W'(cfgQ[REG_PLAIN]);
    lenArr[PH_SGAP]  = CNT_W'(cfgQ[REG_SCR_GAP]) * CNT_W'(TICKS_PER_SLOW);
    lenArr[PH_SCR]   = CNT_W'(cfgQ[REG_SCR]);
    lenArr[PH_DDLY]  = CNT_W'({cfgQ[REG_DLY_HI], cfgQ[REG_DLY_LO]});
    lenArr[PH_DONE]  = '0;
  end

  for (genvar p = 1; p <= 6; p++) begin : g_zero
    assign zeroMask[p] = (lenArr[p] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (strb.load) cnt <= lenArr[strb.loadSel];
    else if (strb.dec)  cnt <= cnt - CNT_W'(1);
  end

  assign cntLast = (cnt == CNT_W'(1));
  assign cntZero = (cnt == '0);

  // receive qualification
  assign rxLen = cfgQ[REG_RX_LEN];

  always_ff @(posedge clk) begin
    if (!rstN || !rxOnesIn)         rxCnt <= '0;
    else if (tickEn && rxCnt < rxLen) rxCnt <= rxCnt + REG_W'(1);
  end

  assign rxQual = rxOnesIn && (rxCnt >= rxLen);

  // R6: the timer never wraps below zero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> !cntZero);

  // R11: with a nonzero length, qualification only rises after a tick edge
  a_r11_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxQual) && $stable(rxLen) && rxLen != '0) |-> $past(tickEn));
endmodule

// File: rtl/hsCtrl.sv
module hsCtrl
  import hsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        start,
  input  logic        abort,
  input  logic [6:1]  zeroMask,
  input  logic        cntLast,
  output phase_t      phase,
  output cntStrobe_t  strb
);
  phase_t nxt;
  logic   active;

  function automatic phase_t firstFrom(input logic [2:0] from, input logic [6:1] zm);
    phase_t r = PH_DONE;
    for (int p = 6; p >= 1; p--) begin
      if (p >= int'(from) && !zm[p]) r = phase_t'(3'(p));
    end
    return r;
  endfunction

  assign active = (phase != PH_IDLE) && (phase != PH_DONE);

  always_comb begin
    nxt  = phase;
    strb = '{load: 1'b0, loadSel: PH_IDLE, dec: 1'b0};
    if (abort) begin
      nxt = PH_IDLE;
    end else if (start && !active) begin
      nxt          = firstFrom(3'(PH_TONE), zeroMask);
      strb.load    = 1'b1;
      strb.loadSel = nxt;
    end else if (tickEn && active) begin
      if (cntLast) begin
        nxt          = firstFrom(3'(phase) + 3'd1, zeroMask);
        strb.load    = 1'b1;
        strb.loadSel = nxt;
      end else begin
        strb.dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nxt;
  end

  // R10: abort lands in idle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> phase == PH_IDLE);

  // R13: no tick, no abort -> an active phase holds
  a_r13_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !abort && active) |=> $stable(phase));

  // R3: phases only move forward except through abort
  a_r3_forward_only: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) != PH_IDLE && $past(phase) != PH_DONE && !$past(abort)
     && phase != $past(phase)) |-> phase > $past(phase));
endmodule

// File: rtl/ansHandshakeSeq.sv
module ansHandshakeSeq
  import hsPkg::*;
#(
  parameter int TICKS_PER_SEC  = 600,
  parameter int TICKS_PER_SLOW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              start,
  input  logic              abort,
  input  logic              fastLoad,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rxOnesIn,
  output logic              txAnsTone,
  output logic              txUnscrOnes,
  output logic              txScrOnes,
  output logic              txData,
  output logic              rxOnesQual,
  output logic              dataReady
);
  logic [NREG-1:0][REG_W-1:0] cfgQ;
  logic [6:1]                 zeroMask;
  logic                       cntLast;
  logic                       cntZero;
  phase_t                     phase;
  cntStrobe_t                 strb;

  hsRegs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .fastLoad(fastLoad), .cfgQ(cfgQ)
  );

  hsDatapath #(.TICKS_PER_SEC(TICKS_PER_SEC), .TICKS_PER_SLOW(TICKS_PER_SLOW)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .cfgQ(cfgQ),
    .rxOnesIn(rxOnesIn), .zeroMask(zeroMask), .cntLast(cntLast),
    .cntZero(cntZero), .rxQual(rxOnesQual)
  );

  hsCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .start(start), .abort(abort),
    .zeroMask(zeroMask), .cntLast(cntLast), .phase(phase), .strb(strb)
  );

  assign txAnsTone   = (phase == PH_TONE);
  assign txUnscrOnes = (phase == PH_PLAIN) || (phase == PH_SGAP);
  assign txScrOnes   = (phase == PH_SCR) || (phase == PH_DDLY);
  assign txData      = (phase == PH_DONE);
  assign dataReady   = txData && rxOnesQual;

  // R8: a phase is never entered with an empty timer
  a_r8_loaded_when_active: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && phase != PH_DONE) |-> !cntZero);

  // R3: at most one transmit selection at a time
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txAnsTone, txUnscrOnes, txScrOnes, txData}));
endmodule

// File: tb/ansHandshakeSeq_tb_top.sv
module ansHandshakeSeq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN, tickEn, start, abort, fastLoad, wrEn, rxOnesIn;
  logic [3:0] wrAddr;
  logic [7:0] wrData;
  logic txAnsTone, txUnscrOnes, txScrOnes, txData, rxOnesQual, dataReady;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ansHandshakeSeq dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .start(start), .abort(abort),
    .fastLoad(fastLoad), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rxOnesIn(rxOnesIn), .txAnsTone(txAnsTone), .txUnscrOnes(txUnscrOnes),
    .txScrOnes(txScrOnes), .txData(txData), .rxOnesQual(rxOnesQual),
    .dataReady(dataReady)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // run a sequence with tickEn high every cycle; count cycles per output code
  task automatic runSeq(output int nT, output int nG, output int nU, output int nS);
    nT = 0; nG = 0; nU = 0; nS = 0;
    tickEn = 1'b1;
    pulseStart();
    for (int i = 0; i < 6000; i++) begin
      if (txData) break;
      if (txAnsTone)        nT++;
      else if (txUnscrOnes) nU++;
      else if (txScrOnes)   nS++;
      else                  nG++;
      @(negedge clk);
    end
  endtask

  task automatic setLens(input int sec, input int fine, input int gap, input int plain,
                         input int sgap, input int scr, input int lo, input int hi);
    wr(0, sec); wr(1, fine); wr(2, gap); wr(3, plain);
    wr(4, sgap); wr(5, scr); wr(6, lo); wr(7, hi);
  endtask

  task automatic testReset();
    check("R1 tone low", int'(txAnsTone), 0);
    check("R1 data low", int'(txData), 0);
    check("R1 ready low", int'(dataReady), 0);
    check("R1 qual low", int'(rxOnesQual), 0);
  endtask

  task automatic testDefaults();
    int nT, nG, nU, nS;
    runSeq(nT, nG, nU, nS);
    check("R2 R4 default tone", nT, 3 * 600);
    check("R2 R6 default gap", nG, 45);
    check("R2 R6 default unscrambled", nU, 93 + 9 * 32);
    check("R2 R7 default scrambled+delay", nS, 162 + 2251);
    check("R3 data reached", int'(txData), 1);
  endtask

  task automatic testFineTone();
    int nT, nG, nU, nS;
    setLens(0, 7, 0, 4, 1, 3, 2, 1);
    runSeq(nT, nG, nU, nS);
    check("R5 fine tone", nT, 7);
    check("R8 zero gap skipped", nG, 0);
    check("R6 unscrambled with gap", nU, 4 + 32);
    check("R7 scrambled with 16-bit delay", nS, 3 + 258);
  endtask

  task automatic testCoarseTone();
    int nT, nG, nU, nS;
    setLens(1, 7, 2, 0, 0, 0, 0, 0);
    runSeq(nT, nG, nU, nS);
    check("R4 coarse tone ignores fine", nT, 600);
    check("R6 tone gap ticks", nG, 2);
    check("R8 zero unscrambled skipped", nU, 0);
    check("R8 zero scrambled skipped", nS, 0);
  endtask

  task automatic testAllZero();
    setLens(0, 0, 0, 0, 0, 0, 0, 0);
    pulseStart();
    check("R8 all zero straight to data", int'(txData), 1);
    check("R8 no tone", int'(txAnsTone), 0);
  endtask

  task automatic testTickGate();
    int n = 0;
    setLens(0, 10, 0, 0, 0, 0, 0, 0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    tickEn = 1'b0;
    pulseStart();
    repeat (20) @(negedge clk);
    check("R13 holds without tick", int'(txAnsTone), 1);
    pulseStart();  // ignored while active
    tickEn = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (!txAnsTone) break;
      n++;
      @(negedge clk);
    end
    check("R13 tone counted only on ticks", n, 10);
    check("R3 R13 data after tone", int'(txData), 1);
  endtask

  task automatic testAbort();
    setLens(0, 5, 0, 0, 0, 50, 0, 0);
    tickEn = 1'b1;
    pulseStart();
    repeat (8) @(negedge clk);
    check("R3 in scrambled phase", int'(txScrOnes), 1);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    check("R10 abort clears scrambled", int'(txScrOnes), 0);
    repeat (3) @(negedge clk);
    check("R10 stays idle", int'({txAnsTone, txUnscrOnes, txScrOnes, txData}), 0);
    abort = 1'b1; start = 1'b1; @(negedge clk); abort = 1'b0; start = 1'b0;
    check("R10 abort beats start", int'(txAnsTone), 0);
  endtask

  task automatic testRxQual();
    wr(8, 5);
    tickEn = 1'b1;
    rxOnesIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 not yet qualified", int'(rxOnesQual), 0);
    @(negedge clk);
    check("R11 qualified after length", int'(rxOnesQual), 1);
    rxOnesIn = 1'b0; #1;
    check("R11 drops with input", int'(rxOnesQual), 0);
    @(negedge clk);
    rxOnesIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 restarts from zero", int'(rxOnesQual), 0);
    rxOnesIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReady();
    wr(8, 3);
    setLens(0, 2, 0, 0, 0, 0, 0, 0);
    tickEn = 1'b1;
    pulseStart();
    repeat (3) @(negedge clk);
    check("R12 data without qual", int'(txData), 1);
    check("R12 not ready", int'(dataReady), 0);
    rxOnesIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 still not ready", int'(dataReady), 0);
    @(negedge clk);
    check("R12 ready", int'(dataReady), 1);
    rxOnesIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testFast();
    int nT, nG, nU, nS;
    fastLoad = 1'b1; wrEn = 1'b1; wrAddr = 4'd1; wrData = 8'h11;
    @(negedge clk);
    fastLoad = 1'b0; wrEn = 1'b0;
    runSeq(nT, nG, nU, nS);
    check("R9 fast tone 0xF0", nT, 240);
    check("R9 fast others zero", nG + nU + nS, 0);
    rxOnesIn = 1'b1; #1;
    check("R9 fast rx length zero", int'(rxOnesQual), 1);
    rxOnesIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; start = 1'b0; abort = 1'b0; fastLoad = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; rxOnesIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDefaults();
    testFineTone();
    testCoarseTone();
    testAllZero();
    testTickGate();
    testAbort();
    testRxQual();
    testReady();
    testFast();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule